// File: doc/BRIEF.md
# Iterative Split-Operand 16-bit Multiplier

This block forms the 32-bit unsigned product of two 16-bit operands. It uses one half-width (8x8) multiplier core four times per product. Each operand is cut into a high byte and a low byte. A 2-bit step counter picks which byte pair reaches the shared core, and a 2-to-4 decoder turns the counter into write strobes for the result storage. Each 16-bit partial product lands in a single temporary register. On the next step that register is weighted, added into a running sum through a ripple-carry adder, and then reloaded with the new partial product.

No start strobe is needed. A change monitor compares the operand inputs with the values it captured last. When they differ, it captures the new pair and starts a fresh sequence, even if an earlier sequence is still in progress. When the last partial product has been folded into the sum, the block raises a one-cycle done pulse and presents the registered product. That product then holds until the next result replaces it.

Top module: `split_mult16`

## Requirements
- R1: When done_o is high, prod_o equals the unsigned product of the a_i and b_i values present in that cycle, with all 32 bits kept.
- R2: Call E0 the clock edge at which a_i or b_i differs from the pair captured at the previous edge. If the inputs then stay unchanged, done_o is high for exactly one cycle, the cycle that follows the fifth edge after E0.
- R3: An input change during a running sequence discards every partial result and restarts from step 0. No done pulse is produced for the abandoned pair.
- R4: An edge at which both inputs equal the captured pair starts nothing. done_o stays low unless it is the R2 pulse of a sequence already running.
- R5: prod_o changes only in the cycle where done_o is high. Between pulses it holds its last value.
- R6: A synchronous active-high reset drives prod_o to 0 and done_o to 0, and clears the captured pair to zero. A zero operand pair applied after reset therefore starts no sequence.
- R7: The steps run in a fixed order with counter value 0: AL·BL, 1: AL·BH, 2: AH·BL, 3: AH·BH. Here H and L are bits 15:8 and 7:0. At most one result-storage write strobe is active in any cycle.
- R8: Extreme operands give exact results: 0xFFFF×0xFFFF = 0xFFFE0001, 0x00FF×0xFF00 = 0x00FE0100, and any operand times 0 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 16 | Multiplicand, unsigned |
| b_i | input | 16 | Multiplier, unsigned |
| prod_o | output | 32 | Registered product |
| done_o | output | 1 | One-cycle pulse: prod_o is a new result |

## Verification
The assertions assume that a_i and b_i change only between clock edges and that the pair seen at each edge is the one to be multiplied. The latency and product checks therefore compare against the inputs present at the done edge. The stimulus drives inputs only on the falling edge. It holds each pair for at least eight cycles, except where a restart is being provoked on purpose. It also reapplies an unchanged pair to show that no new sequence starts.

// File: rtl/split_mult16_pkg.sv
package split_mult16_pkg;
  localparam int unsigned HALF_W  = 8;
  localparam int unsigned OP_W    = 2 * HALF_W;
  localparam int unsigned PROD_W  = 2 * OP_W;
  localparam int unsigned N_STEPS = 4;
  localparam int unsigned CNT_W   = $clog2(N_STEPS);

  // weight applied to a stored partial product before accumulation
  typedef enum logic [1:0] {
    WT_0   = 2'd0,   // x1
    WT_H   = 2'd1,   // x 2^HALF_W
    WT_OP  = 2'd2    // x 2^OP_W
  } wt_e;
endpackage

// File: rtl/spm_opnd_monitor.sv
module spm_opnd_monitor #(
  parameter int unsigned OP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic [OP_W-1:0] op_a,
  output logic [OP_W-1:0] op_b,
  output logic            restart
);
  // a new pair is any pair that differs from the captured one
  assign restart = (a_i != op_a) || (b_i != op_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_a <= '0;
      op_b <= '0;
    end else if (restart) begin
      op_a <= a_i;
      op_b <= b_i;
    end
  end
endmodule

// File: rtl/spm_step_seq.sv
module spm_step_seq #(
  parameter int unsigned N_STEPS = 4,
  localparam int unsigned CNT_W = $clog2(N_STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  output logic [CNT_W-1:0]   cnt,
  output logic               busy,
  output logic               flush,
  output logic [N_STEPS-1:0] wr_stb,
  output logic               done_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy   <= 1'b0;
      flush  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart) begin
        cnt   <= '0;
        busy  <= 1'b1;
        flush <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy  <= 1'b0;
          flush <= 1'b1;
        end
      end else if (flush) begin
        flush  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  // binary-to-one-hot decoder gated by the active phase
  for (genvar k = 0; k < N_STEPS; k++) begin : g_dec
    assign wr_stb[k] = busy && !restart && (cnt == CNT_W'(k));
  end
endmodule

// File: rtl/spm_byte_core.sv
module spm_byte_core #(
  parameter int unsigned HALF_W = 8,
  localparam int unsigned PP_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] x,
  input  logic [HALF_W-1:0] y,
  output logic [PP_W-1:0]   pp
);
  logic [PP_W-1:0] rows [HALF_W];

  for (genvar r = 0; r < HALF_W; r++) begin : g_row
    assign rows[r] = y[r] ? (PP_W'(x) << r) : '0;
  end

  always_comb begin
    pp = '0;
    for (int r = 0; r < HALF_W; r++) begin
      pp = pp + rows[r];
    end
  end
endmodule

// File: rtl/spm_ripple_add.sv
module spm_ripple_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  logic [W-1:0] cin;
  assign cin[0] = 1'b0;

  for (genvar i = 0; i < W - 1; i++) begin : g_fa
    assign cin[i+1] = (x[i] & y[i]) | (x[i] & cin[i]) | (y[i] & cin[i]);
  end

  assign s = x ^ y ^ cin;
endmodule

// File: rtl/spm_pp_accum.sv
module spm_pp_accum
  import split_mult16_pkg::*;
#(
  parameter int unsigned N_STEPS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               flush,
  input  logic [N_STEPS-1:0] wr_stb,
  input  logic [OP_W-1:0]    pp_in,
  output logic [PROD_W-1:0]  prod_q
);
  logic [OP_W-1:0]   tmp_pp;
  wt_e               tmp_wt;
  wt_e               new_wt;
  logic [PROD_W-1:0] sum_q;
  logic [PROD_W-1:0] addend;
  logic [PROD_W-1:0] sum_nxt;
  logic [PROD_W-1:0] tmp_ext;
  logic              any_stb;

  assign any_stb = |wr_stb;
  assign tmp_ext = PROD_W'(tmp_pp);

  // step 0 unweighted, steps 1 and 2 cross terms, step 3 high-high term
  always_comb begin
    new_wt = WT_0;
    if (wr_stb[N_STEPS-1])      new_wt = WT_OP;
    else if (|wr_stb[N_STEPS-2:1]) new_wt = WT_H;
  end

  always_comb begin
    unique case (tmp_wt)
      WT_H:    addend = tmp_ext << HALF_W;
      WT_OP:   addend = tmp_ext << OP_W;
      default: addend = tmp_ext;
    endcase
  end

  spm_ripple_add #(.W(PROD_W)) u_add (
    .x (sum_q),
    .y (addend),
    .s (sum_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_pp <= '0;
      tmp_wt <= WT_0;
      sum_q  <= '0;
      prod_q <= '0;
    end else if (restart) begin
      tmp_pp <= '0;
      tmp_wt <= WT_0;
      sum_q  <= '0;
    end else if (any_stb) begin
      sum_q  <= sum_nxt;
      tmp_pp <= pp_in;
      tmp_wt <= new_wt;
    end else if (flush) begin
      sum_q  <= sum_nxt;
      tmp_pp <= '0;
      tmp_wt <= WT_0;
      prod_q <= sum_nxt;
    end
  end
endmodule

// File: rtl/split_mult16.sv
module split_mult16
  import split_mult16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o,
  output logic              done_o
);
  logic [OP_W-1:0]    op_a;
  logic [OP_W-1:0]    op_b;
  logic               restart;
  logic [CNT_W-1:0]   step_cnt;
  logic               busy;
  logic               flush;
  logic [N_STEPS-1:0] wr_stb;
  logic [HALF_W-1:0]  mux_a;
  logic [HALF_W-1:0]  mux_b;
  logic [OP_W-1:0]    pp;

  spm_opnd_monitor #(.OP_W(OP_W)) u_mon (
    .clk     (clk),
    .rst     (rst),
    .a_i     (a_i),
    .b_i     (b_i),
    .op_a    (op_a),
    .op_b    (op_b),
    .restart (restart)
  );

  spm_step_seq #(.N_STEPS(N_STEPS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (step_cnt),
    .busy    (busy),
    .flush   (flush),
    .wr_stb  (wr_stb),
    .done_q  (done_o)
  );

  // counter bit 1 picks the a half, bit 0 the b half
  assign mux_a = step_cnt[1] ? op_a[OP_W-1:HALF_W] : op_a[HALF_W-1:0];
  assign mux_b = step_cnt[0] ? op_b[OP_W-1:HALF_W] : op_b[HALF_W-1:0];

  spm_byte_core #(.HALF_W(HALF_W)) u_core (
    .x  (mux_a),
    .y  (mux_b),
    .pp (pp)
  );

  spm_pp_accum #(.N_STEPS(N_STEPS)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .flush   (flush),
    .wr_stb  (wr_stb),
    .pp_in   (pp),
    .prod_q  (prod_o)
  );
endmodule

// File: rtl/split_mult16_chk.sv
module split_mult16_chk
  import split_mult16_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic [PROD_W-1:0] prod_o,
  input logic              done_o,
  input logic [N_STEPS-1:0] stb
);
  logic [OP_W-1:0] pa, pb;
  logic [2:0]      since;
  logic            armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pa    <= '0;
      pb    <= '0;
      since <= 3'd7;
      armed <= 1'b0;
    end else begin
      pa    <= a_i;
      pb    <= b_i;
      armed <= 1'b1;
      if ((a_i != pa) || (b_i != pb)) since <= 3'd1;
      else if (since != 3'd7)         since <= since + 3'd1;
    end
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> prod_o == (PROD_W'(a_i) * PROD_W'(b_i)));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd6) |-> done_o);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_no_stale_done_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> since == 3'd6);

  assert_no_spurious_done_R4: assert property (@(posedge clk) disable iff (rst)
    (since == 3'd7) |-> !done_o);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !done_o) |-> $stable(prod_o));

  assert_reset_R6: assert property (@(posedge clk)
    (armed == 1'b0 && !rst) |-> (prod_o == '0 && !done_o));

  assert_onehot_stb_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
endmodule

bind split_mult16 split_mult16_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .a_i    (a_i),
  .b_i    (b_i),
  .prod_o (prod_o),
  .done_o (done_o),
  .stb    (wr_stb)
);

// File: tb/tb_split_mult16.sv
`timescale 1ns/1ps
module tb_split_mult16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [31:0] prod_o;
  logic        done_o;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  logic [15:0] m_a = '0, m_b = '0;
  int          since = 7;
  logic [31:0] exp_prod = '0;
  logic        exp_done = 1'b0;
  int          n_done = 0;

  always #4 clk = ~clk;   // 125 MHz

  split_mult16 dut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i),
    .prod_o(prod_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_a = '0; m_b = '0; since = 7; exp_prod = '0; exp_done = 1'b0;
    end else begin
      if (a_i != m_a || b_i != m_b) since = 1;
      else if (since < 7) since = since + 1;
      m_a = a_i; m_b = b_i;
      exp_done = (since == 6);
      if (exp_done) exp_prod = 32'(a_i) * 32'(b_i);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model (R2 R3 R4 for done, R5 for product)
  always @(negedge clk) begin
    if (!rst) begin
      check(done_o == exp_done, "R2/R3/R4 done", 32'(done_o), 32'(exp_done));
      check(prod_o == exp_prod, "R5/R1 product", prod_o, exp_prod);
    end
  end

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input int cyc);
    @(negedge clk);
    a_i = a; b_i = b;
    repeat (cyc) @(negedge clk);
  endtask

  // explicit result check after a full sequence
  task automatic run_and_check(input logic [15:0] a, input logic [15:0] b,
                               input string req);
    logic [31:0] want;
    want = 32'(a) * 32'(b);
    @(negedge clk);
    a_i = a; b_i = b;
    repeat (6) @(negedge clk);
    check(done_o === 1'b1 && prod_o == want, req, prod_o, want);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(prod_o == 32'd0 && done_o == 1'b0, "R6 reset state", prod_o, 32'd0);
    rst = 1'b0;
    // R6: zero pair after reset starts nothing
    repeat (8) @(negedge clk);
    check(done_o == 1'b0 && prod_o == 32'd0, "R6 zero pair idle", prod_o, 32'd0);

    run_and_check(16'h0001, 16'h0001, "R1 one times one");
    run_and_check(16'hFFFF, 16'hFFFF, "R8 max times max");
    run_and_check(16'h00FF, 16'hFF00, "R8 low by high byte");
    run_and_check(16'hFF00, 16'h00FF, "R7 byte order swap");
    run_and_check(16'h0000, 16'hFFFF, "R8 zero operand");
    run_and_check(16'h0100, 16'h0001, "R7 AH by BL weight");
    run_and_check(16'h0001, 16'h0100, "R7 AL by BH weight");
    run_and_check(16'h8000, 16'h8000, "R7 AH by BH weight");

    // R4: reapplying the same pair starts nothing
    @(negedge clk);
    a_i = 16'h8000; b_i = 16'h8000;
    repeat (8) @(negedge clk);
    check(done_o == 1'b0 && prod_o == 32'h4000_0000, "R4 same pair", prod_o, 32'h4000_0000);

    // R3: change mid-sequence, only a changes
    apply(16'h1234, 16'h5678, 2);
    run_and_check(16'hABCD, 16'h5678, "R3 restart");
    // R3: change at the flush step
    apply(16'h0F0F, 16'h0003, 4);
    run_and_check(16'h0F0F, 16'h0007, "R3 late restart");

    for (int i = 0; i < 40; i++) begin
      run_and_check(16'($urandom), 16'($urandom), "R1 random");
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule